// File: doc/BRIEF.md
# Bus-Mapped Eight-Bit General-Purpose I/O Port

This block gives software eight bidirectional pins through three registers on a small synchronous register bus. One register sets the direction of each pin. One holds the value driven onto the pins. The third returns the levels seen on the pins. The driven value can be written at either the port address or the latch address. Reading the latch address returns what was last written, not what the pins show. A read-modify-write through the latch address therefore stays correct when an output pin is loaded down or is switched to an input.

Some pins can be handed to other functions. An analog-select mask marks pins that feed an analog converter, and those pins read as zero at the port address. Only bits 0, 1, 2, 3 and 5 can be analog. A single oscillator-select input gives bit 6 to a clock oscillator. While it is asserted, bit 6 reads as zero at every address and its driver stays off.

Pin levels pass through a two-stage synchronizer before software can see them. Read data is combinational from the address. Writes take effect at the clock edge where the write strobe is high.

Top module: `gpio_port8`

## Requirements
- R1: After reset (synchronous, active high) the direction register reads 0xFF, so every pin is an input and pin_oe is 0x00. The output latch reads 0x00 and pin_out is 0x00.
- R2: pin_out always equals the output latch. pin_oe[i] is the inverse of direction bit i (1 = input, tri-stated). This holds even while that pin is selected as analog.
- R3: A write to address 0 (port) or address 1 (latch) loads bus_wdata into the output latch. The new value appears on pin_out and on latch reads in the cycle after the write edge.
- R4: A write to address 2 loads the direction register. Writing 0xCF makes bits 5:4 outputs and all other bits inputs, so pin_oe reads 0x30.
- R5: A read at address 1 returns the output latch, never the pin levels. A read at address 2 returns the direction register.
- R6: A read at address 0 returns the pin levels after two clock edges. A level applied before edge k is visible after edge k+1, and the old value is returned until then.
- R7: At address 0, bit i reads 0 when analog_sel[i] is 1 and i is one of bits 0, 1, 2, 3 or 5. analog_sel bits 4, 6 and 7 have no effect.
- R8: While osc_sel is 1, bit 6 reads 0 at addresses 0, 1 and 2, and pin_oe[6] is 0. The stored latch and direction bits are kept and read back once osc_sel returns to 0.
- R9: Address 3 reads 0x00, and a write to it changes neither the latch nor the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 port, 1 latch, 2 direction, 3 unused |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| analog_sel | input | 8 | Per-pin analog selection mask |
| osc_sel | input | 1 | Bit 6 is given to the oscillator |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Value driven onto the pins |
| pin_oe | output | 8 | Per-pin output enable, 1 = drive |

## Verification
The hardest case to reach is the two-edge window in which a changed pin level is inside the synchronizer but not yet readable. The stimulus changes pin_in right after an edge and reads the port address in the same cycle, after one more edge and after a second edge. It expects the old value twice and the new value only on the third read. The latch-versus-pin difference needs the pins and the latch to hold different patterns at the same moment, so the stimulus sets them to unrelated values before reading both addresses. Analog masking and oscillator masking are applied on top of a known pin pattern, so that every masked bit would otherwise have read as one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GP_W = 8;

    typedef enum logic [1:0] {
        SEL_PORT = 2'd0,
        SEL_LAT  = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [GP_W-1:0] dir;
        logic [GP_W-1:0] lat;
    } gp_regs_t;

    localparam logic [GP_W-1:0] DIR_RST = '1;
    localparam logic [GP_W-1:0] LAT_RST = '0;

    function automatic logic [GP_W-1:0] bit_mask(input bit en, input int pos);
        logic [GP_W-1:0] m;
        m = '0;
        if (en) m[pos] = 1'b1;
        return m;
    endfunction

    function automatic logic writes_latch(input reg_sel_e s);
        return (s == SEL_PORT) || (s == SEL_LAT);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  reg_sel_e        sel,
    input  logic [GP_W-1:0] wdata,
    output gp_regs_t        q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q.dir <= DIR_RST;
            q.lat <= LAT_RST;
        end else if (we) begin
            if (writes_latch(sel)) q.lat <= wdata;
            if (sel == SEL_DIR)    q.dir <= wdata;
        end
    end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
    import gpio_pkg::*;
#(
    parameter logic [GP_W-1:0] ANALOG_CAP = 8'h2F,
    parameter int              OSC_BIT    = 6
) (
    input  reg_sel_e        sel,
    input  gp_regs_t        regs,
    input  logic [GP_W-1:0] pins_sync,
    input  logic [GP_W-1:0] analog_sel,
    input  logic            osc_sel,
    output logic [GP_W-1:0] rdata
);
    logic [GP_W-1:0] an_eff;
    logic [GP_W-1:0] osc_m;
    logic [GP_W-1:0] raw;

    always_comb begin
        an_eff = analog_sel & ANALOG_CAP;
        osc_m  = bit_mask(osc_sel, OSC_BIT);
        unique case (sel)
            SEL_PORT: raw = pins_sync & ~an_eff;
            SEL_LAT:  raw = regs.lat;
            SEL_DIR:  raw = regs.dir;
            default:  raw = '0;
        endcase
        rdata = raw & ~osc_m;
    end
endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
    import gpio_pkg::*;
#(
    parameter logic [GP_W-1:0] ANALOG_CAP  = 8'h2F,
    parameter int              OSC_BIT     = 6,
    parameter int              SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      bus_addr,
    input  logic            bus_we,
    input  logic [GP_W-1:0] bus_wdata,
    output logic [GP_W-1:0] bus_rdata,
    input  logic [GP_W-1:0] analog_sel,
    input  logic            osc_sel,
    input  logic [GP_W-1:0] pin_in,
    output logic [GP_W-1:0] pin_out,
    output logic [GP_W-1:0] pin_oe
);
    reg_sel_e        sel;
    gp_regs_t        regs;
    logic [GP_W-1:0] pins_sync;

    assign sel = reg_sel_e'(bus_addr);

    gpio_sync #(.W(GP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pins_sync)
    );

    gpio_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .sel   (sel),
        .wdata (bus_wdata),
        .q     (regs)
    );

    gpio_rdmux #(.ANALOG_CAP(ANALOG_CAP), .OSC_BIT(OSC_BIT)) u_rdmux (
        .sel        (sel),
        .regs       (regs),
        .pins_sync  (pins_sync),
        .analog_sel (analog_sel),
        .osc_sel    (osc_sel),
        .rdata      (bus_rdata)
    );

    assign pin_out = regs.lat;
    assign pin_oe  = ~regs.dir & ~bit_mask(osc_sel, OSC_BIT);
endmodule

// File: rtl/gpio_port8_chk.sv
module gpio_port8_chk
    import gpio_pkg::*;
#(
    parameter logic [GP_W-1:0] ANALOG_CAP = 8'h2F,
    parameter int              OSC_BIT    = 6
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      bus_addr,
    input logic            bus_we,
    input logic [GP_W-1:0] bus_wdata,
    input logic [GP_W-1:0] bus_rdata,
    input logic [GP_W-1:0] analog_sel,
    input logic            osc_sel,
    input logic [GP_W-1:0] pin_out,
    input logic [GP_W-1:0] pin_oe
);
    a_r3_latch_load: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == 2'd0 || bus_addr == 2'd1)) |=> (pin_out == $past(bus_wdata)));

    a_r4_dir_load: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd2) |=>
        (pin_oe == (~$past(bus_wdata) & ~bit_mask(osc_sel, OSC_BIT))));

    a_r5_latch_read: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd1 && !osc_sel) |-> (bus_rdata == pin_out));

    a_r7_analog_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd0) |-> ((bus_rdata & analog_sel & ANALOG_CAP) == '0));

    a_r8_osc_bit: assert property (@(posedge clk) disable iff (rst)
        osc_sel |-> (!bus_rdata[OSC_BIT] && !pin_oe[OSC_BIT]));

    a_r9_unused_read: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));

    a_r9_unused_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd3) |=> ($stable(pin_out) && $stable(pin_oe | bit_mask(1'b1, OSC_BIT))));
endmodule

bind gpio_port8 gpio_port8_chk #(.ANALOG_CAP(ANALOG_CAP), .OSC_BIT(OSC_BIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .analog_sel (analog_sel),
    .osc_sel    (osc_sel),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
);

// File: tb/gpio_port8_bench.sv
module gpio_port8_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] analog_sel = 8'h00;
    logic       osc_sel = 1'b0;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    localparam int K_RD = 0, K_OUT = 1, K_OE = 2;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    gpio_port8 u_gpio_port8 (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .analog_sel (analog_sel),
        .osc_sel    (osc_sel),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    // monitor: pops expected items and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                act = (it.kind == K_RD) ? bus_rdata : (it.kind == K_OUT) ? pin_out : pin_oe;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input int kind, input logic [1:0] a, input logic [7:0] e, input string tag);
        bus_addr = a;
        sb.push_back('{kind, e, tag});
        @(negedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        expect_val(K_RD,  2'd2, 8'hFF, "R1 dir reset");
        expect_val(K_RD,  2'd1, 8'h00, "R1 latch reset");
        expect_val(K_OE,  2'd0, 8'h00, "R1 oe reset");
        expect_val(K_OUT, 2'd0, 8'h00, "R1 out reset");
        // R3 writes through both addresses
        bus_write(2'd0, 8'hA5);
        expect_val(K_OUT, 2'd0, 8'hA5, "R3 port write");
        expect_val(K_RD,  2'd1, 8'hA5, "R5 latch read");
        bus_write(2'd1, 8'h3C);
        expect_val(K_OUT, 2'd1, 8'h3C, "R3 latch write");
        // R4 / R2 direction
        bus_write(2'd2, 8'hCF);
        expect_val(K_OE,  2'd2, 8'h30, "R4 dir CF");
        expect_val(K_RD,  2'd2, 8'hCF, "R5 dir read");
        expect_val(K_OUT, 2'd2, 8'h3C, "R2 out equals latch");
        // R6 synchronizer latency
        @(posedge clk); #1;
        pin_in = 8'h55;
        expect_val(K_RD, 2'd0, 8'h00, "R6 edge0 old");
        @(posedge clk); #1;
        expect_val(K_RD, 2'd0, 8'h00, "R6 edge1 old");
        @(posedge clk); #1;
        expect_val(K_RD, 2'd0, 8'h55, "R6 edge2 new");
        expect_val(K_RD, 2'd1, 8'h3C, "R5 latch not pins");
        // R7 analog masking
        pin_in = 8'hFF;
        analog_sel = 8'hFF;
        settle();
        expect_val(K_RD, 2'd0, 8'hD0, "R7 analog all");
        expect_val(K_OE, 2'd0, 8'h30, "R2 dir rules analog pins");
        analog_sel = 8'hD0;
        expect_val(K_RD, 2'd0, 8'hFF, "R7 non-capable ignored");
        analog_sel = 8'h00;
        // R8 oscillator bit
        bus_write(2'd1, 8'h7F);
        bus_write(2'd2, 8'h00);
        osc_sel = 1'b1;
        expect_val(K_OE, 2'd0, 8'hBF, "R8 oe bit6 off");
        expect_val(K_RD, 2'd0, 8'hBF, "R8 port bit6");
        expect_val(K_RD, 2'd1, 8'h3F, "R8 latch bit6");
        bus_write(2'd2, 8'h40);
        expect_val(K_RD, 2'd2, 8'h00, "R8 dir bit6");
        osc_sel = 1'b0;
        expect_val(K_RD, 2'd2, 8'h40, "R8 dir kept");
        expect_val(K_RD, 2'd1, 8'h7F, "R8 latch kept");
        // R9 unused address
        expect_val(K_RD, 2'd3, 8'h00, "R9 read zero");
        bus_write(2'd3, 8'hAA);
        expect_val(K_RD, 2'd1, 8'h7F, "R9 latch unchanged");
        expect_val(K_RD, 2'd2, 8'h40, "R9 dir unchanged");
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule